// File: doc/BRIEF.md
# SPI Controller Interrupt and Test Register Block

This block holds the module-wide interrupt state of a four-channel SPI controller. Each channel engine reports, after every transfer attempt, its transmit-holding-empty and receive-holding-full flags, its transfer direction mode and its turbo setting. The block turns these into latched per-channel TX-empty and RX-full status bits. It masks them with a software enable register and drives one level-sensitive interrupt line.

Software reaches the block through a simple word-addressed write port and a combinational read port. Status bits are cleared by writing ones. A system-test mode lets a test register force every implemented status bit high. While a strobe bit in that register is set, software status writes are ignored. A write to the configuration register can request a soft reset, which returns the block to its reset state and emits a one-cycle pulse for the channel engines.

The test-mode control is a four-state machine over two flags, test mode and strobe. The states are MS_NORMAL (neither flag set), MS_NORMAL_SSB (strobe only), MS_TEST (test mode only) and MS_TEST_SSB (both flags, status locked). A mode-register write moves the machine between the NORMAL and TEST halves and keeps the strobe. A test-register write moves it between the plain and SSB variants and keeps the mode. A soft reset returns it to MS_NORMAL.

Top module: `spi_irq_ctrl`

## Requirements
- R1: After reset, every register reads 0 except the system status register, and `irq` is low. Register word addresses are: 0 config, 1 system status, 2 interrupt status, 3 interrupt enable, 4 test, 5 mode control.
- R2: Channel c reports TX-empty in status bit 4·c and RX-full in status bit 4·c+2.
- R3: An event is recorded only in a cycle where the channel's `ch_attempt` is high. TX-empty is recorded when `ch_txs` is 1 and the mode is not receive-only. RX-full is recorded when `ch_rxs` is 1, the mode is not transmit-only and `ch_turbo` is 0. The two-bit mode encodings are 0 full duplex, 1 receive-only, 2 transmit-only and 3 reserved, and the reserved mode behaves as full duplex.
- R4: A write to the status register clears each bit written as 1 and leaves bits written as 0 unchanged. If a clear and a new event hit the same bit in the same cycle, the bit stays set.
- R5: The interrupt enable register keeps only the bits in mask 0x1777F.
- R6: `irq` is high exactly when some bit is set in both status and enable. It reflects a register change in the cycle after the write or event edge.
- R7: The test register keeps its low 12 bits, and its bit 11 is the strobe. The mode register keeps its low 4 bits, and its bit 3 is test mode.
- R8: While test mode and the strobe are both set, writes to the status register have no effect.
- R9: Status is forced to 0x1777F in two cases: a test-register write with bit 11 set while in test mode, or a mode-register write with bit 3 set while the strobe is set. A strobe write outside test mode forces nothing.
- R10: The config register keeps mask 0x31D. A config write with bit 1 set returns every register of the block to its reset value, and `soft_rst` is high for the one cycle after that write.
- R11: The system status register always reads 1, and writes to it have no effect. Addresses 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| ch_attempt | input | NCH | Per-channel transfer-attempt pulse |
| ch_txs | input | NCH | Per-channel transmit holding empty flag |
| ch_rxs | input | NCH | Per-channel receive holding full flag |
| ch_mode | input | 2·NCH | Per-channel direction mode, two bits each |
| ch_turbo | input | NCH | Per-channel turbo setting |
| soft_rst | output | 1 | One-cycle pulse after a soft-reset request |
| irq | output | 1 | Level interrupt |

## Verification
Every channel is swept through all 32 combinations of TXS, RXS, mode and turbo. This separates the receive-only and transmit-only gating from the turbo suppression, and pins each channel's bit positions. Pulses with the attempt line low show that stale flags are not latched. An enable sweep over all 17 bits against a fixed status pattern checks the AND-reduction, bit by bit. The test-mode walk visits all four machine states. It shows that a strobe written outside test mode does not force, that entering test mode with the strobe set does force, and that status writes are ignored only in the locked state.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
    localparam logic [2:0] ADDR_SYSCFG  = 3'd0;
    localparam logic [2:0] ADDR_SYSSTAT = 3'd1;
    localparam logic [2:0] ADDR_STAT    = 3'd2;
    localparam logic [2:0] ADDR_EN      = 3'd3;
    localparam logic [2:0] ADDR_TEST    = 3'd4;
    localparam logic [2:0] ADDR_MODE    = 3'd5;

    localparam logic [31:0] SYSCFG_MASK = 32'h0000_031D;
    localparam logic [31:0] EN_MASK     = 32'h0001_777F;
    localparam int TEST_W       = 12;
    localparam int SSB_BIT      = 11;
    localparam int MODE_W       = 4;
    localparam int TESTMODE_BIT = 3;
    localparam int SRST_BIT     = 1;
    localparam int CH_STRIDE    = 4;
    localparam int RXF_OFS      = 2;

    typedef enum logic [1:0] {
        MS_NORMAL     = 2'b00,
        MS_NORMAL_SSB = 2'b01,
        MS_TEST       = 2'b10,
        MS_TEST_SSB   = 2'b11
    } test_state_e;

    typedef enum logic [1:0] {
        TRM_DUPLEX  = 2'd0,
        TRM_RX_ONLY = 2'd1,
        TRM_TX_ONLY = 2'd2,
        TRM_RSVD    = 2'd3
    } trm_e;
endpackage

// File: rtl/spi_irq_mode_fsm.sv
module spi_irq_mode_fsm
    import spi_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic soft_clr,
    input  logic wr_mode,
    input  logic mode_bit,
    input  logic wr_test,
    input  logic ssb_bit,
    output logic test_on,
    output logic ssb_on,
    output logic locked,
    output logic force_set
);
    test_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MS_NORMAL;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MS_NORMAL: begin
                if (wr_mode && mode_bit)     state_d = MS_TEST;
                else if (wr_test && ssb_bit) state_d = MS_NORMAL_SSB;
            end
            MS_NORMAL_SSB: begin
                if (wr_mode && mode_bit)      state_d = MS_TEST_SSB;
                else if (wr_test && !ssb_bit) state_d = MS_NORMAL;
            end
            MS_TEST: begin
                if (wr_mode && !mode_bit)    state_d = MS_NORMAL;
                else if (wr_test && ssb_bit) state_d = MS_TEST_SSB;
            end
            MS_TEST_SSB: begin
                if (wr_mode && !mode_bit)     state_d = MS_NORMAL_SSB;
                else if (wr_test && !ssb_bit) state_d = MS_TEST;
            end
            default: state_d = MS_NORMAL;
        endcase
        if (soft_clr) state_d = MS_NORMAL;
    end

    always_comb begin
        test_on = 1'b0;
        ssb_on  = 1'b0;
        unique case (state_q)
            MS_NORMAL:     begin test_on = 1'b0; ssb_on = 1'b0; end
            MS_NORMAL_SSB: begin test_on = 1'b0; ssb_on = 1'b1; end
            MS_TEST:       begin test_on = 1'b1; ssb_on = 1'b0; end
            MS_TEST_SSB:   begin test_on = 1'b1; ssb_on = 1'b1; end
            default:       begin test_on = 1'b0; ssb_on = 1'b0; end
        endcase
        locked    = test_on && ssb_on;
        force_set = !soft_clr &&
                    ((wr_mode && mode_bit && ssb_on) || (wr_test && ssb_bit && test_on));
    end
endmodule

// File: rtl/spi_irq_event_map.sv
module spi_irq_event_map
    import spi_irq_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int STAT_W = 17
) (
    input  logic [NCH-1:0]   ch_attempt,
    input  logic [NCH-1:0]   ch_txs,
    input  logic [NCH-1:0]   ch_rxs,
    input  logic [2*NCH-1:0] ch_mode,
    input  logic [NCH-1:0]   ch_turbo,
    output logic [STAT_W-1:0] evt
);
    logic [NCH-1:0] tx_hit, rx_hit;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        trm_e trm;
        assign trm       = trm_e'(ch_mode[2*c +: 2]);
        assign tx_hit[c] = ch_attempt[c] && ch_txs[c] && (trm != TRM_RX_ONLY);
        assign rx_hit[c] = ch_attempt[c] && ch_rxs[c] && (trm != TRM_TX_ONLY) && !ch_turbo[c];
    end

    always_comb begin
        evt = '0;
        for (int c = 0; c < NCH; c++) begin
            evt[CH_STRIDE*c]           = tx_hit[c];
            evt[CH_STRIDE*c + RXF_OFS] = rx_hit[c];
        end
    end
endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status
    import spi_irq_pkg::*;
#(
    parameter int STAT_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_clr,
    input  logic              force_set,
    input  logic              clr_we,
    input  logic [STAT_W-1:0] clr_mask,
    input  logic              en_we,
    input  logic [STAT_W-1:0] en_wdata,
    input  logic [STAT_W-1:0] evt,
    output logic [STAT_W-1:0] stat_q,
    output logic [STAT_W-1:0] en_q
);
    localparam logic [STAT_W-1:0] IMPL_MASK = EN_MASK[STAT_W-1:0];

    logic [STAT_W-1:0] clr_eff;
    assign clr_eff = clr_we ? clr_mask : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
            en_q   <= '0;
        end else if (soft_clr) begin
            stat_q <= '0;
            en_q   <= '0;
        end else begin
            if (force_set) stat_q <= IMPL_MASK;
            else           stat_q <= (stat_q & ~clr_eff) | evt;
            if (en_we)     en_q   <= en_wdata & IMPL_MASK;
        end
    end
endmodule

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl
    import spi_irq_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int STAT_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [2:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic [NCH-1:0]   ch_attempt,
    input  logic [NCH-1:0]   ch_txs,
    input  logic [NCH-1:0]   ch_rxs,
    input  logic [2*NCH-1:0] ch_mode,
    input  logic [NCH-1:0]   ch_turbo,
    output logic             soft_rst,
    output logic             irq
);
    localparam int PAD_W = 32 - STAT_W;

    logic wr_sys, wr_stat, wr_en, wr_test, wr_mode, soft_clr;
    logic test_on, ssb_on, locked, force_set;
    logic [STAT_W-1:0] evt, stat_q, en_q;
    logic [31:0] sys_q;
    logic [TEST_W-2:0] test_lo_q;
    logic [TESTMODE_BIT-1:0] mode_lo_q;
    logic soft_rst_q;
    logic unused_wdata;

    assign wr_sys   = reg_wr && (reg_addr == ADDR_SYSCFG);
    assign wr_stat  = reg_wr && (reg_addr == ADDR_STAT);
    assign wr_en    = reg_wr && (reg_addr == ADDR_EN);
    assign wr_test  = reg_wr && (reg_addr == ADDR_TEST);
    assign wr_mode  = reg_wr && (reg_addr == ADDR_MODE);
    assign soft_clr = wr_sys && reg_wdata[SRST_BIT];
    assign unused_wdata = ^reg_wdata[31:STAT_W];

    spi_irq_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_clr (soft_clr),
        .wr_mode  (wr_mode),
        .mode_bit (reg_wdata[TESTMODE_BIT]),
        .wr_test  (wr_test),
        .ssb_bit  (reg_wdata[SSB_BIT]),
        .test_on  (test_on),
        .ssb_on   (ssb_on),
        .locked   (locked),
        .force_set(force_set)
    );

    spi_irq_event_map #(.NCH(NCH), .STAT_W(STAT_W)) u_map (
        .ch_attempt(ch_attempt),
        .ch_txs    (ch_txs),
        .ch_rxs    (ch_rxs),
        .ch_mode   (ch_mode),
        .ch_turbo  (ch_turbo),
        .evt       (evt)
    );

    spi_irq_status #(.STAT_W(STAT_W)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_clr (soft_clr),
        .force_set(force_set),
        .clr_we   (wr_stat && !locked),
        .clr_mask (reg_wdata[STAT_W-1:0]),
        .en_we    (wr_en),
        .en_wdata (reg_wdata[STAT_W-1:0]),
        .evt      (evt),
        .stat_q   (stat_q),
        .en_q     (en_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sys_q      <= '0;
            test_lo_q  <= '0;
            mode_lo_q  <= '0;
            soft_rst_q <= 1'b0;
        end else begin
            soft_rst_q <= soft_clr;
            if (soft_clr) begin
                sys_q     <= '0;
                test_lo_q <= '0;
                mode_lo_q <= '0;
            end else begin
                if (wr_sys)  sys_q     <= reg_wdata & SYSCFG_MASK;
                if (wr_test) test_lo_q <= reg_wdata[TEST_W-2:0];
                if (wr_mode) mode_lo_q <= reg_wdata[TESTMODE_BIT-1:0];
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_SYSCFG:  reg_rdata = sys_q;
            ADDR_SYSSTAT: reg_rdata = 32'd1;
            ADDR_STAT:    reg_rdata = {{PAD_W{1'b0}}, stat_q};
            ADDR_EN:      reg_rdata = {{PAD_W{1'b0}}, en_q};
            ADDR_TEST:    reg_rdata = {{(32-TEST_W){1'b0}}, ssb_on, test_lo_q};
            ADDR_MODE:    reg_rdata = {{(32-MODE_W){1'b0}}, test_on, mode_lo_q};
            default:      reg_rdata = '0;
        endcase
    end

    assign soft_rst = soft_rst_q;
    assign irq      = |(stat_q & en_q);
endmodule

// File: rtl/spi_irq_ctrl_chk.sv
module spi_irq_ctrl_chk
    import spi_irq_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int STAT_W = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [2:0]        reg_addr,
    input logic [31:0]       reg_wdata,
    input logic [31:0]       reg_rdata,
    input logic [NCH-1:0]    ch_attempt,
    input logic              soft_rst,
    input logic              irq,
    input logic [STAT_W-1:0] stat_q,
    input logic [STAT_W-1:0] en_q,
    input logic              locked
);
    // R4: written ones are cleared when unlocked and no event arrives
    a_r4_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && reg_wr && reg_addr == ADDR_STAT && !(|ch_attempt))
        |=> ((stat_q & $past(reg_wdata[STAT_W-1:0])) == '0));

    // R5: enable keeps only implemented bits
    a_r5_en_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_EN)
        |=> (en_q == ($past(reg_wdata[STAT_W-1:0]) & EN_MASK[STAT_W-1:0])));

    // R6: clearing the enable silences the interrupt
    a_r6_irq_off: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_EN && reg_wdata == 32'd0) |=> !irq);

    // R8: locked status ignores software writes
    a_r8_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && reg_wr && reg_addr == ADDR_STAT && !(|ch_attempt))
        |=> (stat_q == $past(stat_q)));

    // R10: soft reset clears state and pulses the output
    a_r10_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_SYSCFG && reg_wdata[SRST_BIT])
        |=> (soft_rst && stat_q == '0 && en_q == '0 && !irq));

    // R11: system status constant
    a_r11_sysstat: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_SYSSTAT) |-> (reg_rdata == 32'd1));
endmodule

bind spi_irq_ctrl spi_irq_ctrl_chk #(.NCH(NCH), .STAT_W(STAT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .ch_attempt(ch_attempt),
    .soft_rst  (soft_rst),
    .irq       (irq),
    .stat_q    (stat_q),
    .en_q      (en_q),
    .locked    (locked)
);

// File: tb/spi_irq_ctrl_test.sv
module spi_irq_ctrl_test;
    localparam int NCH = 4;
    localparam logic [31:0] IMPL = 32'h1777F;

    logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic [NCH-1:0] ch_attempt = '0, ch_txs = '0, ch_rxs = '0, ch_turbo = '0;
    logic [2*NCH-1:0] ch_mode = '0;
    logic soft_rst, irq;
    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    spi_irq_ctrl #(.NCH(NCH), .STAT_W(17)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ch_attempt(ch_attempt),
        .ch_txs(ch_txs), .ch_rxs(ch_rxs), .ch_mode(ch_mode), .ch_turbo(ch_turbo),
        .soft_rst(soft_rst), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse(input logic [NCH-1:0] att);
        @(negedge clk);
        ch_attempt = att;
        @(negedge clk);
        ch_attempt = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, exp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            check("R1 reset read", d, (a == 1) ? 32'd1 : 32'd0);
        end
        check("R1 irq low", {31'd0, irq}, 32'd0);

        // R5 enable mask
        wr(3'd3, 32'hFFFF_FFFF); rd(3'd3, d); check("R5 enable mask", d, IMPL);
        wr(3'd3, 32'h0); rd(3'd3, d); check("R5 enable clear", d, 32'd0);

        // R2 R3 per-channel sweep of every flag combination
        for (int c = 0; c < NCH; c++) begin
            for (int k = 0; k < 32; k++) begin
                logic tx, rx, tb;
                logic [1:0] md;
                tx = k[0]; rx = k[1]; md = k[3:2]; tb = k[4];
                wr(3'd2, 32'h1FFFF);
                ch_txs = '0; ch_rxs = '0; ch_turbo = '0; ch_mode = '0;
                ch_txs[c] = tx; ch_rxs[c] = rx; ch_turbo[c] = tb; ch_mode[2*c +: 2] = md;
                pulse(NCH'(1) << c);
                exp = 32'd0;
                if (tx && md != 2'd1) exp[4*c] = 1'b1;
                if (rx && md != 2'd2 && !tb) exp[4*c+2] = 1'b1;
                rd(3'd2, d);
                check("R2 R3 event sweep", d, exp);
            end
        end

        // R3 no attempt, no event
        wr(3'd2, 32'h1FFFF);
        ch_txs = '1; ch_rxs = '1; ch_mode = '0; ch_turbo = '0;
        repeat (3) @(negedge clk);
        rd(3'd2, d); check("R3 no attempt", d, 32'd0);

        // R2 all channels at once
        pulse('1);
        rd(3'd2, d); check("R2 all channels", d, 32'h5555);

        // R6 enable sweep against status 0x5555
        for (int b = 0; b < 17; b++) begin
            wr(3'd3, 32'd1 << b);
            exp = ((32'h5555 & IMPL) >> b) & 32'd1;
            check("R6 irq bit sweep", {31'd0, irq}, exp);
        end
        wr(3'd3, 32'h0);
        check("R6 irq off", {31'd0, irq}, 32'd0);

        // R4 write-one-to-clear
        wr(3'd2, 32'h0000_0001); rd(3'd2, d); check("R4 clear one", d, 32'h5554);
        wr(3'd2, 32'h0); rd(3'd2, d); check("R4 zero write", d, 32'h5554);
        @(negedge clk);
        reg_addr = 3'd2; reg_wdata = 32'h0000_0010; reg_wr = 1'b1; ch_attempt = 4'b0010;
        @(negedge clk);
        reg_wr = 1'b0; ch_attempt = '0;
        rd(3'd2, d); check("R4 clear with event", d, 32'h5554);
        wr(3'd2, 32'h1FFFF); rd(3'd2, d); check("R4 clear all", d, 32'd0);

        // R7 R9 test register and mode register
        wr(3'd4, 32'hFFFF_F7FF); rd(3'd4, d); check("R7 test width", d, 32'h7FF);
        wr(3'd4, 32'hFFFF_FFFF); rd(3'd4, d); check("R7 strobe kept", d, 32'hFFF);
        rd(3'd2, d); check("R9 no force outside test", d, 32'd0);
        wr(3'd5, 32'hFF); rd(3'd5, d); check("R7 mode width", d, 32'hF);
        rd(3'd2, d); check("R9 force on mode entry", d, IMPL);

        // R8 locked
        wr(3'd2, 32'h1FFFF); rd(3'd2, d); check("R8 write ignored", d, IMPL);
        wr(3'd4, 32'h0); rd(3'd2, d); check("R8 strobe off keeps", d, IMPL);
        wr(3'd2, 32'h1FFFF); rd(3'd2, d); check("R8 unlocked clear", d, 32'd0);
        wr(3'd4, 32'h800); rd(3'd2, d); check("R9 force on strobe", d, IMPL);
        wr(3'd3, 32'h1); check("R6 irq on forced", {31'd0, irq}, 32'd1);

        // R10 config mask and soft reset
        wr(3'd0, 32'hFFFF_FFFD); rd(3'd0, d); check("R10 config mask", d, 32'h31D);
        @(negedge clk);
        reg_addr = 3'd0; reg_wdata = 32'h2; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        check("R10 soft pulse", {31'd0, soft_rst}, 32'd1);
        check("R10 irq cleared", {31'd0, irq}, 32'd0);
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), d);
            check("R10 regs cleared", d, (a == 1) ? 32'd1 : 32'd0);
        end
        @(negedge clk);
        check("R10 pulse one cycle", {31'd0, soft_rst}, 32'd0);

        // R11 system status and unused addresses
        wr(3'd1, 32'h0); rd(3'd1, d); check("R11 sysstat", d, 32'd1);
        rd(3'd6, d); check("R11 addr6", d, 32'd0);
        rd(3'd7, d); check("R11 addr7", d, 32'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule